// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two 16-bit operands and a carry input without a ripple chain anywhere in its carry path. Every bit position forms a local generate (both operand bits set) and a local propagate (either operand bit set). Four identical 4-bit groups each expand their internal carries as flat sum-of-products terms. Each group also exports a group generate and a group propagate.

A second lookahead stage of the same flat form takes those four generate/propagate pairs and the carry input. It produces the carry entering each group and a block-wide generate/propagate pair. The carry-out comes from that block-wide pair. Because the pair is also driven out of the block, several adders can be placed under a further lookahead stage to form a wider adder.

The block is purely combinational and holds no state. All outputs follow the present inputs within the same cycle.

Top module: `cla16_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + cin_i`, taken as unsigned numbers.
- R2: `cout_o` equals bit 16 of the 17-bit unsigned sum `a_i + b_i + cin_i`.
- R3: The carry entering group k (bits 4k to 4k+3, k = 0..3) equals the carry of adding the operand bits below bit 4k plus `cin_i`. This is seen at the ports as `sum_o[4k]` = `a_i[4k]` XOR `b_i[4k]` XOR that carry.
- R4: `pg_o` is 1 exactly when every one of the 16 bit positions has `a_i` or `b_i` set, and 0 otherwise.
- R5: `gg_o` is 1 exactly when `a_i + b_i`, with no carry input, exceeds 16'hFFFF, and 0 otherwise.
- R6: `cout_o` equals `gg_o` OR (`pg_o` AND `cin_i`) for every input, so the pair can be cascaded.
- R7: The block holds no state. The same inputs give the same outputs whatever inputs came before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |
| pg_o | output | 1 | Block propagate for cascading |
| gg_o | output | 1 | Block generate for cascading |

## Verification
The checks sit in combinational processes. They assume the operands and carry input hold known 0/1 values and are stable while they are evaluated. The bench meets this by driving every input from a defined value before the first evaluation, and by changing inputs only on the falling clock edge. The group-carry check also relies on the lookahead result matching plain binary addition across group boundaries. The stimulus therefore concentrates on carries that must cross one, two or all group boundaries: all-ones patterns, patterns with a single generate bit below a run of propagates, and alternating patterns with both carry-input values.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Per-bit lookahead terms
  typedef struct packed {
    logic gen;
    logic prop;
    logic half;
  } bit_terms_t;
endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg
  import cla_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] gen_o,
  output logic [WIDTH-1:0] prop_o,
  output logic [WIDTH-1:0] half_o
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    bit_terms_t terms;
    always_comb begin
      terms.gen  = a_i[i] & b_i[i];
      terms.prop = a_i[i] | b_i[i];
      terms.half = a_i[i] ^ b_i[i];
    end
    assign gen_o[i]  = terms.gen;
    assign prop_o[i] = terms.prop;
    assign half_o[i] = terms.half;
  end

endmodule

// File: rtl/cla_lookahead.sv
// Flat sum-of-products lookahead over N generate/propagate pairs.
// carry_o[0] is the incoming carry; carry_o[j] is the carry into position j.
module cla_lookahead #(
  parameter int N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prop_i,
  input  logic         cin_i,
  output logic [N-1:0] carry_o,
  output logic         grp_gen_o,
  output logic         grp_prop_o
);

  logic [N:0] carries;
  logic       grp_gen;

  // Each carry is an OR of product terms built from inputs only
  always_comb begin
    logic acc;
    logic prod;
    carries    = '0;
    carries[0] = cin_i;
    for (int j = 0; j < N; j++) begin
      acc = 1'b0;
      for (int k = 0; k <= j; k++) begin
        prod = gen_i[k];
        for (int m = k + 1; m <= j; m++) begin
          prod = prod & prop_i[m];
        end
        acc = acc | prod;
      end
      prod = cin_i;
      for (int m = 0; m <= j; m++) begin
        prod = prod & prop_i[m];
      end
      carries[j+1] = acc | prod;
    end
  end

  // Group generate: same expansion with a zero incoming carry
  always_comb begin
    logic prod;
    grp_gen = 1'b0;
    for (int k = 0; k < N; k++) begin
      prod = gen_i[k];
      for (int m = k + 1; m < N; m++) begin
        prod = prod & prop_i[m];
      end
      grp_gen = grp_gen | prod;
    end
  end

  assign carry_o    = carries[N-1:0];
  assign grp_gen_o  = grp_gen;
  assign grp_prop_o = &prop_i;

endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int GROUP_W = 4
) (
  input  logic [GROUP_W-1:0] a_i,
  input  logic [GROUP_W-1:0] b_i,
  input  logic               cin_i,
  output logic [GROUP_W-1:0] sum_o,
  output logic               grp_gen_o,
  output logic               grp_prop_o
);

  logic [GROUP_W-1:0] gen;
  logic [GROUP_W-1:0] prop;
  logic [GROUP_W-1:0] half;
  logic [GROUP_W-1:0] carry;

  cla_bit_pg #(.WIDTH(GROUP_W)) u_pg (
    .a_i    (a_i),
    .b_i    (b_i),
    .gen_o  (gen),
    .prop_o (prop),
    .half_o (half)
  );

  cla_lookahead #(.N(GROUP_W)) u_la (
    .gen_i      (gen),
    .prop_i     (prop),
    .cin_i      (cin_i),
    .carry_o    (carry),
    .grp_gen_o  (grp_gen_o),
    .grp_prop_o (grp_prop_o)
  );

  assign sum_o = half ^ carry;

endmodule

// File: rtl/cla16_adder.sv
module cla16_adder #(
  parameter int GROUP_W = 4,
  parameter int GROUPS  = 4,
  localparam int W      = GROUP_W * GROUPS
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         pg_o,
  output logic         gg_o
);

  logic [GROUPS-1:0] grp_gen;
  logic [GROUPS-1:0] grp_prop;
  logic [GROUPS-1:0] grp_cin;

  for (genvar k = 0; k < GROUPS; k++) begin : g_grp
    cla_group #(.GROUP_W(GROUP_W)) u_grp (
      .a_i        (a_i[k*GROUP_W +: GROUP_W]),
      .b_i        (b_i[k*GROUP_W +: GROUP_W]),
      .cin_i      (grp_cin[k]),
      .sum_o      (sum_o[k*GROUP_W +: GROUP_W]),
      .grp_gen_o  (grp_gen[k]),
      .grp_prop_o (grp_prop[k])
    );
  end

  // Second level: carries into each group and block-wide pair
  cla_lookahead #(.N(GROUPS)) u_top_la (
    .gen_i      (grp_gen),
    .prop_i     (grp_prop),
    .cin_i      (cin_i),
    .carry_o    (grp_cin),
    .grp_gen_o  (gg_o),
    .grp_prop_o (pg_o)
  );

  assign cout_o = gg_o | (pg_o & cin_i);

endmodule

// File: rtl/cla16_adder_chk.sv
module cla16_adder_chk #(
  parameter int GROUP_W = 4,
  parameter int GROUPS  = 4,
  localparam int W      = GROUP_W * GROUPS
) (
  input logic [W-1:0]      a_i,
  input logic [W-1:0]      b_i,
  input logic              cin_i,
  input logic [W-1:0]      sum_o,
  input logic              cout_o,
  input logic              pg_o,
  input logic              gg_o,
  input logic [GROUPS-1:0] grp_cin
);

  logic [W:0] full_sum;
  logic [W:0] raw_sum;

  assign full_sum = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
  assign raw_sum  = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    p_sum_r1: assert (sum_o == full_sum[W-1:0])
      else $error("R1 sum mismatch");
    p_cout_r2: assert (cout_o == full_sum[W])
      else $error("R2 carry-out mismatch");
    p_pg_r4: assert (pg_o == &(a_i | b_i))
      else $error("R4 block propagate mismatch");
    p_gg_r5: assert (gg_o == raw_sum[W])
      else $error("R5 block generate mismatch");
  end

  // R3: carry into each group equals arithmetic carry at its low bit
  for (genvar k = 0; k < GROUPS; k++) begin : g_chk
    always_comb begin
      p_grp_carry_r3: assert (grp_cin[k] ==
        (full_sum[k*GROUP_W] ^ a_i[k*GROUP_W] ^ b_i[k*GROUP_W]))
        else $error("R3 group carry mismatch");
    end
  end

endmodule

bind cla16_adder cla16_adder_chk #(.GROUP_W(GROUP_W), .GROUPS(GROUPS)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .cin_i   (cin_i),
  .sum_o   (sum_o),
  .cout_o  (cout_o),
  .pg_o    (pg_o),
  .gg_o    (gg_o),
  .grp_cin (grp_cin)
);

// File: tb/test_cla16_adder.sv
`timescale 1ns/1ps
module test_cla16_adder;

  logic        clk;
  logic        rst_n;
  logic [15:0] a_r;
  logic [15:0] b_r;
  logic        cin_r;
  logic [15:0] sum_w;
  logic        cout_w;
  logic        pg_w;
  logic        gg_w;

  int n_tests;
  int n_fail;
  bit done;

  cla16_adder i_cla16_adder (
    .a_i    (a_r),
    .b_i    (b_r),
    .cin_i  (cin_r),
    .sum_o  (sum_w),
    .cout_o (cout_w),
    .pg_o   (pg_w),
    .gg_o   (gg_w)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (a=%h b=%h cin=%0d)",
               req, act, exp, a_r, b_r, cin_r);
    end
  endtask

  // Drive on falling edge, compare after the rising edge
  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c);
    logic [16:0] full;
    logic [16:0] raw;
    @(negedge clk);
    a_r = a; b_r = b; cin_r = c;
    @(posedge clk); #1;
    full = 17'(a) + 17'(b) + 17'(c);
    raw  = 17'(a) + 17'(b);
    chk("R1 sum", 32'(sum_w), 32'(full[15:0]));
    chk("R2 cout", 32'(cout_w), 32'(full[16]));
    chk("R4 pg", 32'(pg_w), 32'(&(a | b)));
    chk("R5 gg", 32'(gg_w), 32'(raw[16]));
    chk("R6 cascade", 32'(cout_w), 32'((raw[16]) | ((&(a | b)) & c)));
    for (int k = 0; k < 4; k++) begin
      chk("R3 group carry bit", 32'(sum_w[4*k]), 32'(full[4*k]));
    end
  endtask

  initial begin
    n_tests = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    a_r = '0; b_r = '0; cin_r = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    // Reset-state check with zero inputs
    chk("R1 reset sum", 32'(sum_w), 32'h0);
    chk("R2 reset cout", 32'(cout_w), 32'h0);
    chk("R4 reset pg", 32'(pg_w), 32'h0);
    chk("R5 reset gg", 32'(gg_w), 32'h0);
    rst_n = 1'b1;

    // Boundary patterns
    apply(16'hFFFF, 16'h0001, 1'b0);
    apply(16'hFFFF, 16'h0000, 1'b1);
    apply(16'hFFFF, 16'h0000, 1'b0);
    apply(16'hFFFF, 16'hFFFF, 1'b1);
    apply(16'hFFFF, 16'hFFFF, 1'b0);
    apply(16'hAAAA, 16'h5555, 1'b0);
    apply(16'hAAAA, 16'h5555, 1'b1);
    apply(16'h5555, 16'h5555, 1'b1);
    apply(16'hAAAA, 16'hAAAA, 1'b0);
    // R3: carries crossing one, two and three group boundaries
    apply(16'h000F, 16'h0001, 1'b0);
    apply(16'h00FF, 16'h0000, 1'b1);
    apply(16'h0FFF, 16'h0001, 1'b0);
    apply(16'h0F0F, 16'h00F1, 1'b0);
    apply(16'h8000, 16'h8000, 1'b0);
    apply(16'h0000, 16'h0000, 1'b1);

    // R7: same vector after different histories
    begin
      logic [15:0] s1;
      logic        c1;
      apply(16'h1234, 16'hEDCB, 1'b1);
      s1 = sum_w; c1 = cout_w;
      apply(16'hFFFF, 16'hFFFF, 1'b1);
      apply(16'h1234, 16'hEDCB, 1'b1);
      chk("R7 stateless sum", 32'(sum_w), 32'(s1));
      chk("R7 stateless cout", 32'(cout_w), 32'(c1));
    end

    // Random operand pairs, both carry-in values
    for (int i = 0; i < 3000; i++) begin
      apply(16'($urandom), 16'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule